// File: doc/BRIEF.md
# CPU Clock Source and Prescaler Control

This block holds the byte-wide clock control register of the CPU and the clocking logic behind it. Software writes a source choice and a divide ratio. The CPU clock then comes either from the main clock, divided by a power of two from 1 to 32, or from the slow subclock. Every change of source or ratio is handed over with a synchronized enable per clock lane. The old lane is switched off while its clock is low, and the new lane is switched on only after the old one is fully off. The output therefore never carries a truncated pulse.

A read-only status field reports the source that is really driving the CPU. It does not report the source that was asked for. The status moves only after a handover has completed. The status also decides when the main oscillator may stop. A stop request has no effect while the CPU still runs from the main clock. Once the CPU is running from the subclock, the oscillator enable drops. Selecting the main clock again raises the oscillator enable at once.

While the external clock-output function is active, the source and ratio fields are locked. Writes that carry a prohibited ratio code leave the old ratio in place.

Top module: `cpu_clk_ctrl`

## Requirements
- R1: After reset, rdata reads 0x03, osc_main_en is 1, and cpu_clk runs at the main clock divided by 8.
- R2: With bit 3 clear, bits [2:0] hold a ratio code. Codes 0 to 5 make cpu_clk equal to the main clock divided by 2 to the power of the code.
- R3: With bit 3 set, cpu_clk follows the subclock, and the ratio code in bits [2:0] has no effect on cpu_clk.
- R4: Bit 4 is read-only. It reads 0 while the CPU runs from the main clock and 1 while it runs from the subclock. A write to bit 4 does not change it.
- R5: A write that carries ratio code 6 or 7 keeps the previous ratio code. The other fields of the same write still take effect.
- R6: While clkout_en is 1, writes leave bits [3:0] unchanged. Bit 5 is still written.
- R7: Bit 4 changes only once a handover has completed. In the cycle after the write that requests a new source, it still shows the old source.
- R8: Bit 5 requests a stop of the main oscillator. osc_main_en is 0 only when bit 5 is 1, bit 3 is 1 and bit 4 reads 1. With bit 3 cleared, osc_main_en returns to 1 in the next cycle.
- R9: During any change of source or ratio, every high and low phase of cpu_clk lasts at least half a period of the main clock. At most one clock lane is enabled at any time.
- R10: Bits [7:6] read as 0 whatever was written to them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | 8 | Register write data |
| rdata | output | 8 | Register read data, including live status |
| clkout_en | input | 1 | Clock-output function active; locks source and ratio |
| main_clk | input | 1 | Main oscillator clock |
| sub_clk | input | 1 | Subclock |
| osc_main_en | output | 1 | Main oscillator enable |
| cpu_clk | output | 1 | Selected CPU clock |

## Verification
The bench walks every legal ratio and measures the period of cpu_clk, and it records the shortest high and low phases across each handover. A mux that switches lanes at an arbitrary moment would show a phase shorter than half a main period there. The status bit is read in the cycle right after a source request, where it must still show the old source, and again after the handover. A design that reported the requested source would fail the first read. The oscillator enable is followed through a stop request issued while the CPU is on the main clock, then through a switch to the subclock, and then through a return to the main clock. A design that stopped the oscillator early, or never restarted it, would leave cpu_clk frozen. Writes carrying prohibited codes, writes made while the clock output is active, and writes to the status and unused bits are each read back to confirm they had no effect.

// File: rtl/ckctl_pkg.sv
package ckctl_pkg;

    localparam int RATIO_COUNT = 6;
    localparam int DIV_W       = 3;

    localparam logic [DIV_W-1:0] DIV_RESET = 3'd3;

    localparam int B_SEL  = 3;
    localparam int B_STAT = 4;
    localparam int B_STOP = 5;

    typedef enum logic {
        SRC_MAIN = 1'b0,
        SRC_SUB  = 1'b1
    } ck_src_e;

    typedef struct packed {
        logic             stop_req;
        logic             sub_sel;
        logic [DIV_W-1:0] div;
    } ck_cfg_t;

    localparam ck_cfg_t CFG_RESET = '{stop_req: 1'b0, sub_sel: 1'b0, div: DIV_RESET};

    function automatic logic div_ok(input logic [DIV_W-1:0] code, input int nrat);
        return int'(code) < nrat;
    endfunction

    function automatic logic [7:0] rd_pack(input ck_cfg_t c, input ck_src_e s);
        logic [7:0] r;
        r            = '0;
        r[DIV_W-1:0] = c.div;
        r[B_SEL]     = c.sub_sel;
        r[B_STAT]    = s;
        r[B_STOP]    = c.stop_req;
        return r;
    endfunction

endpackage

// File: rtl/ckctl_sync.sv
module ckctl_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
            stg[0] <= d;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign q = stg[STAGES-1];

endmodule

// File: rtl/ckctl_regs.sv
module ckctl_regs
    import ckctl_pkg::*;
#(
    parameter  int NUM_RATIOS = RATIO_COUNT,
    localparam int LANES      = NUM_RATIOS + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wdata,
    input  logic             clkout_en,
    input  logic             sub_live,
    input  logic             main_live,
    output ck_cfg_t          cfg,
    output ck_src_e          cur_src,
    output logic [LANES-1:0] lane_req,
    output logic [7:0]       rdata,
    output logic             osc_main_en
);

    ck_cfg_t    cfg_nxt;
    logic [1:0] live_s;

    // write filtering: stop bit always, source/ratio only when unlocked,
    // ratio only when legal
    always_comb begin
        cfg_nxt = cfg;
        if (wr_en) begin
            cfg_nxt.stop_req = wdata[B_STOP];
            if (!clkout_en) begin
                cfg_nxt.sub_sel = wdata[B_SEL];
                if (div_ok(wdata[DIV_W-1:0], NUM_RATIOS)) begin
                    cfg_nxt.div = wdata[DIV_W-1:0];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cfg <= CFG_RESET;
        else     cfg <= cfg_nxt;
    end

    ckctl_sync #(.W(2), .STAGES(2)) u_live_sync (
        .clk (clk),
        .rst (rst),
        .d   ({sub_live, main_live}),
        .q   (live_s)
    );

    // status follows the lane that is actually on
    always_ff @(posedge clk) begin
        if (rst)            cur_src <= SRC_MAIN;
        else if (live_s[1]) cur_src <= SRC_SUB;
        else if (live_s[0]) cur_src <= SRC_MAIN;
    end

    always_comb begin
        lane_req = '0;
        if (cfg.sub_sel) lane_req[LANES-1] = 1'b1;
        else             lane_req[cfg.div] = 1'b1;
    end

    assign osc_main_en = !(cfg.stop_req && cfg.sub_sel && (cur_src == SRC_SUB));
    assign rdata       = rd_pack(cfg, cur_src);

    a_r6_lock_while_clkout: assert property (@(posedge clk) disable iff (rst)
        (wr_en && clkout_en) |=> ($stable(cfg.div) && $stable(cfg.sub_sel)))
        else $error("R6 source/ratio changed while clock output active");

    a_r5_bad_code_kept: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !div_ok(wdata[DIV_W-1:0], NUM_RATIOS)) |=> $stable(cfg.div))
        else $error("R5 prohibited ratio code was stored");

endmodule

// File: rtl/ckctl_divtaps.sv
module ckctl_divtaps #(
    parameter  int NUM_RATIOS = 6,
    localparam int CW         = (NUM_RATIOS > 1) ? NUM_RATIOS - 1 : 1
) (
    input  logic                  main_clk,
    input  logic                  rst,
    output logic [NUM_RATIOS-1:0] taps
);

    logic [CW-1:0] cnt;

    always_ff @(posedge main_clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt + 1'b1;
    end

    assign taps[0] = main_clk;

    for (genvar k = 1; k < NUM_RATIOS; k++) begin : g_tap
        assign taps[k] = cnt[k-1];
    end

endmodule

// File: rtl/ckctl_gmux.sv
module ckctl_gmux
    import ckctl_pkg::*;
#(
    parameter  int NUM_RATIOS = RATIO_COUNT,
    localparam int LANES      = NUM_RATIOS + 1
) (
    input  logic                  main_clk,
    input  logic                  sub_clk,
    input  logic                  rst,
    input  logic [NUM_RATIOS-1:0] taps,
    input  logic [LANES-1:0]      lane_req,
    output logic [LANES-1:0]      lane_en,
    output logic                  cpu_clk
);

    logic [LANES-1:0] lane_s1;
    logic [LANES-1:0] busy;
    logic [LANES-1:0] lane_clk;

    assign busy     = lane_s1 | lane_en;
    assign lane_clk = {sub_clk, taps};

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic s1_q;
        logic en_q;
        logic others;

        assign others = |(busy & ~(LANES'(1) << i));

        if (i == LANES - 1) begin : g_sub
            always_ff @(negedge sub_clk) begin
                if (rst) begin
                    s1_q <= 1'b0;
                    en_q <= 1'b0;
                end else begin
                    s1_q <= lane_req[i] & ~others;
                    en_q <= s1_q;
                end
            end
        end else if (i == 0) begin : g_full
            always_ff @(negedge main_clk) begin
                if (rst) begin
                    s1_q <= 1'b0;
                    en_q <= 1'b0;
                end else begin
                    s1_q <= lane_req[i] & ~others;
                    en_q <= s1_q;
                end
            end
        end else begin : g_div
            // enable moves only while this tap is low
            always_ff @(negedge main_clk) begin
                if (rst) begin
                    s1_q <= 1'b0;
                    en_q <= 1'b0;
                end else begin
                    s1_q <= lane_req[i] & ~others;
                    if (!taps[i]) en_q <= s1_q;
                end
            end
        end

        assign lane_s1[i] = s1_q;
        assign lane_en[i] = en_q;
    end

    assign cpu_clk = |(lane_clk & lane_en);

    always_comb begin
        if (!rst) begin
            a_r9_one_lane: assert ($onehot0(lane_en))
                else $error("R9 more than one clock lane enabled");
        end
    end

endmodule

// File: rtl/cpu_clk_ctrl.sv
module cpu_clk_ctrl
    import ckctl_pkg::*;
#(
    parameter  int NUM_RATIOS = RATIO_COUNT,
    localparam int LANES      = NUM_RATIOS + 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       clkout_en,
    input  logic       main_clk,
    input  logic       sub_clk,
    output logic       osc_main_en,
    output logic       cpu_clk
);

    ck_cfg_t                cfg;
    ck_src_e                cur_src;
    logic [LANES-1:0]       lane_req;
    logic [LANES-1:0]       lane_en;
    logic [NUM_RATIOS-1:0]  taps;
    logic                   main_live;
    logic                   sub_live;

    assign main_live = |lane_en[NUM_RATIOS-1:0];
    assign sub_live  = lane_en[LANES-1];

    ckctl_regs #(.NUM_RATIOS(NUM_RATIOS)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wdata       (wdata),
        .clkout_en   (clkout_en),
        .sub_live    (sub_live),
        .main_live   (main_live),
        .cfg         (cfg),
        .cur_src     (cur_src),
        .lane_req    (lane_req),
        .rdata       (rdata),
        .osc_main_en (osc_main_en)
    );

    ckctl_divtaps #(.NUM_RATIOS(NUM_RATIOS)) u_taps (
        .main_clk (main_clk),
        .rst      (rst),
        .taps     (taps)
    );

    ckctl_gmux #(.NUM_RATIOS(NUM_RATIOS)) u_gmux (
        .main_clk (main_clk),
        .sub_clk  (sub_clk),
        .rst      (rst),
        .taps     (taps),
        .lane_req (lane_req),
        .lane_en  (lane_en),
        .cpu_clk  (cpu_clk)
    );

    a_r8_osc_off_only_on_sub: assert property (@(posedge clk) disable iff (rst)
        !osc_main_en |-> !main_live)
        else $error("R8 main oscillator stopped while a main lane is on");

endmodule

// File: tb/tb_cpu_clk_ctrl.sv
`timescale 1ns/100ps
module tb_cpu_clk_ctrl;

    localparam int MAIN_HALF = 6;
    localparam int MAIN_PER  = 2 * MAIN_HALF;
    localparam int SUB_PER   = 200;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       clkout_en = 1'b0;
    logic       main_clk = 1'b0;
    logic       sub_clk = 1'b0;
    logic       osc_main_en;
    logic       cpu_clk;

    int total = 0;
    int bad   = 0;

    cpu_clk_ctrl dut (
        .clk         (clk),
        .rst         (rst),
        .wr_en       (wr_en),
        .wdata       (wdata),
        .rdata       (rdata),
        .clkout_en   (clkout_en),
        .main_clk    (main_clk),
        .sub_clk     (sub_clk),
        .osc_main_en (osc_main_en),
        .cpu_clk     (cpu_clk)
    );

    always #10 clk = ~clk;
    always #(SUB_PER/2) sub_clk = ~sub_clk;
    always begin
        #(MAIN_HALF);
        if (osc_main_en) main_clk = ~main_clk;
    end

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_min(input string tag, input int act, input int lim);
        total++;
        if (act < lim) begin
            bad++;
            $display("FAIL %s: actual=%0d expected>=%0d", tag, act, lim);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1;
        wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic settle();
        repeat (100) @(negedge clk);
    endtask

    task automatic period_of(output int per);
        int rises = 0;
        int last  = 0;
        logic prev;
        per  = -1;
        #0.5;
        prev = cpu_clk;
        for (int n = 1; n < 3000 && rises < 3; n++) begin
            #1;
            if (cpu_clk && !prev) begin
                rises++;
                if (rises == 3) per = n - last;
                last = n;
            end
            prev = cpu_clk;
        end
    endtask

    task automatic watch(input int len, output int minhi, output int minlo);
        logic prev;
        int   run = 1;
        bit   first = 1'b1;
        minhi = 100000;
        minlo = 100000;
        #0.5;
        prev = cpu_clk;
        for (int n = 0; n < len; n++) begin
            #1;
            if (cpu_clk == prev) begin
                run++;
            end else begin
                if (!first) begin
                    if (prev) begin if (run < minhi) minhi = run; end
                    else      begin if (run < minlo) minlo = run; end
                end
                first = 1'b0;
                run   = 1;
                prev  = cpu_clk;
            end
        end
    endtask

    task automatic t_reset();
        int p;
        chk("R1 rdata after reset", rdata, 8'h03);
        chk("R1 osc enable after reset", osc_main_en, 1);
        period_of(p);
        chk("R1 period main/8", p, MAIN_PER << 3);
    endtask

    task automatic t_ratios();
        int p, mh, ml;
        for (int c = 0; c < 6; c++) begin
            wr(8'(c));
            watch(1500, mh, ml);
            chk_min("R9 min high phase", mh, MAIN_HALF);
            chk_min("R9 min low phase", ml, MAIN_HALF);
            @(negedge clk);
            chk("R2 ratio readback", rdata, c);
            period_of(p);
            chk("R2 period", p, MAIN_PER << c);
        end
    endtask

    task automatic t_bad_code();
        int p, mh, ml;
        wr(8'h06);
        chk("R5 code 6 keeps ratio", rdata[2:0], 5);
        wr(8'h07);
        chk("R5 code 7 keeps ratio", rdata[2:0], 5);
        period_of(p);
        chk("R5 period unchanged", p, MAIN_PER << 5);
        wr(8'h0F);
        chk("R7 status old after request", rdata[4], 0);
        watch(1500, mh, ml);
        chk_min("R9 min high phase to sub", mh, MAIN_HALF);
        chk_min("R9 min low phase to sub", ml, MAIN_HALF);
        settle();
        chk("R5 source applied ratio kept", rdata, 8'h1D);
        period_of(p);
        chk("R3 period on subclock", p, SUB_PER);
    endtask

    task automatic t_sub();
        int p;
        wr(8'h0A);
        settle();
        chk("R3 ratio field stored on sub", rdata[2:0], 2);
        period_of(p);
        chk("R3 ratio ignored on sub", p, SUB_PER);
        wr(8'h08);
        settle();
        chk("R4 status write ignored on sub", rdata[4], 1);
        wr(8'h02);
        chk("R7 status still sub", rdata[4], 1);
        settle();
        chk("R4 status main after return", rdata[4], 0);
        period_of(p);
        chk("R2 period after return", p, MAIN_PER << 2);
        wr(8'h12);
        settle();
        chk("R4 status write ignored on main", rdata, 8'h02);
    endtask

    task automatic t_clkout();
        int p;
        wr(8'h01);
        settle();
        clkout_en = 1'b1;
        wr(8'h04);
        chk("R6 ratio locked", rdata[2:0], 1);
        wr(8'h09);
        settle();
        chk("R6 source locked", rdata[3], 0);
        chk("R6 status stays main", rdata[4], 0);
        period_of(p);
        chk("R6 period unchanged", p, MAIN_PER << 1);
        wr(8'h21);
        chk("R6 stop bit still written", rdata[5], 1);
        chk("R8 osc on while on main", osc_main_en, 1);
        wr(8'h01);
        clkout_en = 1'b0;
        wr(8'h04);
        settle();
        chk("R6 unlocked ratio", rdata[2:0], 4);
    endtask

    task automatic t_osc();
        int p;
        wr(8'h21);
        settle();
        chk("R8 stop request ignored on main", osc_main_en, 1);
        period_of(p);
        chk("R8 main still running", p, MAIN_PER << 1);
        wr(8'h29);
        chk("R8 osc on until handover", osc_main_en, 1);
        chk("R7 status old right after write", rdata[4], 0);
        settle();
        chk("R8 osc off on sub", osc_main_en, 0);
        chk("R7 status after handover", rdata[4], 1);
        period_of(p);
        chk("R8 cpu on sub with osc off", p, SUB_PER);
        wr(8'h21);
        chk("R8 osc restarts on main select", osc_main_en, 1);
        settle();
        chk("R4 status main after restart", rdata[4], 0);
        period_of(p);
        chk("R8 main period after restart", p, MAIN_PER << 1);
        wr(8'h01);
    endtask

    task automatic t_reserved();
        wr(8'hC2);
        chk("R10 upper bits read zero", rdata[7:6], 0);
        chk("R10 readback", rdata, 8'h02);
    endtask

    initial begin
        #1_000_000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (40) @(negedge clk);
        rst = 1'b0;
        settle();
        t_reset();
        t_ratios();
        t_bad_code();
        t_sub();
        t_clkout();
        t_osc();
        t_reserved();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule